// File: doc/BRIEF.md
# E1 CRC4 Interworking Alignment Controller

This block decides, on an E1 receiver, whether the link runs with CRC4 multiframing or drops back to plain doubleframe operation. It starts working when the framer reports basic frame lock. At that moment it records the lock position as the primary alignment. It then counts millisecond ticks while the framer looks for the CRC4 multiframe pattern. Bit-level pattern hunting and CRC arithmetic are done elsewhere; this block only keeps time, chooses the mode and chooses the alignment position.

Once the short parallel-search threshold has passed, the framer may report a second basic-frame candidate position, and the block remembers it. All receive functions still follow the primary position during this time. If a multiframe is found, the framer tags it with a slot index. Slot 0 means the primary position and slot 1 the recorded candidate. The block moves the selected position to the tagged one and enables CRC checking. If no multiframe arrives before the long limit, the block switches to non-CRC4 mode and stays on the primary position. An extended-interworking setting stops that switch, and the search then continues with no time limit.

Top module: `e1_mf_interwork_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it, every output is 0, including `sel_pos`.
- R2: In the first cycle that `bfa_lock` is seen high after it was low, `bfa_pos` is taken as the primary position. From the next cycle it appears on `sel_pos`, the block is searching, and `crc_chk_en` and `ebit_force_low` are both 0.
- R3: `par_search` goes to 1 once 8 ticks (T_PAR) have been counted while searching. A `cand_pos` that arrives with `cand_valid` is recorded only while `par_search` is 1. `sel_pos` does not change while the search runs.
- R4: `mf_found` while searching moves the block into CRC4 mode. In that mode `crc_chk_en` is 1, `ebit_force_low` is 0, and the two are never 1 together.
- R5: `mf_found` with `mf_slot`=1, when a candidate has been recorded, loads that candidate onto `sel_pos`. With `mf_slot`=0, or with no recorded candidate, `sel_pos` keeps the primary position.
- R6: `mon_en` is 1 exactly when the block is in CRC4 mode and `cfg_mon_en` is 1.
- R7: When `cfg_ext_iw`=0 and 400 ticks (T_LIMIT) pass while searching without `mf_found`, the block moves to non-CRC4 mode on the next clock. In that cycle `t400_irq` pulses for one cycle, `no_mf_flag` goes to 1, `ebit_force_low` is 1 and `crc_chk_en` is 0. `sel_pos` stays on the primary position even if a candidate was recorded. After exactly 400 ticks, and before that clock, none of this has happened yet.
- R8: In non-CRC4 mode `mf_found` is ignored. Once `no_mf_flag` is set it stays set through loss and regain of lock until reset.
- R9: When `cfg_ext_iw`=1, the block never falls back and never pulses `t400_irq`. The search continues past T_LIMIT, and a later `mf_found` still moves the block into CRC4 mode.
- R10: When `bfa_lock` goes low, the next cycle shows `crc_chk_en`, `ebit_force_low`, `mon_en` and `par_search` at 0. When lock returns, both tick counts start again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_ext_iw | input | 1 | Extended interworking: never fall back |
| cfg_mon_en | input | 1 | Allow CRC4 monitoring once multiframed |
| bfa_lock | input | 1 | Basic frame alignment held by framer |
| bfa_pos | input | POS_W | Position index of the basic alignment at lock |
| cand_valid | input | 1 | Parallel search reports a candidate |
| cand_pos | input | POS_W | Candidate position index |
| mf_found | input | 1 | Multiframe alignment found (pulse) |
| mf_slot | input | 1 | 0: found on primary, 1: found on candidate |
| ms_tick | input | 1 | One-cycle pulse each millisecond |
| sel_pos | output | POS_W | Alignment position in use |
| no_mf_flag | output | 1 | Sticky: fell back to non-CRC4 |
| t400_irq | output | 1 | One-cycle pulse at fallback |
| crc_chk_en | output | 1 | CRC bit checking enabled |
| ebit_force_low | output | 1 | Received E-bits forced to 0 |
| mon_en | output | 1 | CRC4 performance monitoring enabled |
| par_search | output | 1 | Parallel basic-frame search active |

## Verification
The hardest case to reach from the ports is a timeout while a candidate is already recorded. That case shows whether the fallback keeps the primary position. The stimulus first counts past the parallel threshold, offers a candidate, and then issues exactly 400 ticks. It samples once before the deciding clock and once after it. Lock is also dropped midway through a long count, to show that the limit is measured from the regained lock and not from the first one.

// File: rtl/e1iw_pkg.sv
package e1iw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_CRC4   = 2'd2,
        ST_NOCRC  = 2'd3
    } iw_state_e;

    typedef struct packed {
        logic crc_chk;
        logic ebit_low;
        logic mon;
    } iw_ctrl_t;

    function automatic iw_ctrl_t decode_ctrl(iw_state_e st, logic mon_cfg);
        iw_ctrl_t c;
        c.crc_chk  = (st == ST_CRC4);
        c.ebit_low = (st == ST_NOCRC);
        c.mon      = (st == ST_CRC4) && mon_cfg;
        return c;
    endfunction

endpackage

// File: rtl/e1iw_ms_timer.sv
module e1iw_ms_timer #(
    parameter int T_PAR   = 8,
    parameter int T_LIMIT = 400
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic par_due,
    output logic limit_hit
);
    localparam int CNT_W = $clog2(T_LIMIT + 1);
    localparam logic [CNT_W-1:0] PAR_V = CNT_W'(T_PAR);
    localparam logic [CNT_W-1:0] LIM_V = CNT_W'(T_LIMIT);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (tick && (cnt < LIM_V)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign par_due   = (cnt >= PAR_V);
    assign limit_hit = (cnt >= LIM_V);
endmodule

// File: rtl/e1iw_pos_sel.sv
module e1iw_pos_sel #(
    parameter int POS_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_prim,
    input  logic [POS_W-1:0] prim_in,
    input  logic             cap_en,
    input  logic             cand_valid,
    input  logic [POS_W-1:0] cand_pos,
    input  logic             adopt_alt,
    output logic [POS_W-1:0] sel_pos,
    output logic             alt_valid
);
    logic [POS_W-1:0] prim_q;
    logic [POS_W-1:0] alt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prim_q    <= '0;
            alt_q     <= '0;
            alt_valid <= 1'b0;
        end else if (load_prim) begin
            prim_q    <= prim_in;
            alt_valid <= 1'b0;
        end else if (adopt_alt) begin
            prim_q    <= alt_q;
            alt_valid <= 1'b0;
        end else if (cap_en && cand_valid) begin
            alt_q     <= cand_pos;
            alt_valid <= 1'b1;
        end
    end

    assign sel_pos = prim_q;
endmodule

// File: rtl/e1iw_mode_fsm.sv
module e1iw_mode_fsm
    import e1iw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      lock,
    input  logic      mf_found,
    input  logic      limit_hit,
    input  logic      ext_iw,
    output iw_state_e state,
    output logic      irq,
    output logic      no_mf
);
    iw_state_e nxt;
    logic      fall;

    always_comb begin
        nxt  = state;
        fall = 1'b0;
        unique case (state)
            ST_IDLE:   if (lock) nxt = ST_SEARCH;
            ST_SEARCH: begin
                if (!lock) begin
                    nxt = ST_IDLE;
                end else if (mf_found) begin
                    nxt = ST_CRC4;
                end else if (limit_hit && !ext_iw) begin
                    nxt  = ST_NOCRC;
                    fall = 1'b1;
                end
            end
            ST_CRC4, ST_NOCRC: if (!lock) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            irq   <= 1'b0;
            no_mf <= 1'b0;
        end else begin
            state <= nxt;
            irq   <= fall;
            if (fall) no_mf <= 1'b1;
        end
    end
endmodule

// File: rtl/e1_mf_interwork_ctrl.sv
module e1_mf_interwork_ctrl
    import e1iw_pkg::*;
#(
    parameter int POS_W   = 8,
    parameter int T_PAR   = 8,
    parameter int T_LIMIT = 400
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_ext_iw,
    input  logic             cfg_mon_en,
    input  logic             bfa_lock,
    input  logic [POS_W-1:0] bfa_pos,
    input  logic             cand_valid,
    input  logic [POS_W-1:0] cand_pos,
    input  logic             mf_found,
    input  logic             mf_slot,
    input  logic             ms_tick,
    output logic [POS_W-1:0] sel_pos,
    output logic             no_mf_flag,
    output logic             t400_irq,
    output logic             crc_chk_en,
    output logic             ebit_force_low,
    output logic             mon_en,
    output logic             par_search
);
    iw_state_e state;
    iw_ctrl_t  ctrl;
    logic      par_due;
    logic      limit_hit;
    logic      alt_valid;
    logic      searching;
    logic      mf_take;

    assign searching = (state == ST_SEARCH) && bfa_lock;
    assign mf_take   = searching && mf_found;

    e1iw_ms_timer #(.T_PAR(T_PAR), .T_LIMIT(T_LIMIT)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (searching),
        .tick      (ms_tick),
        .par_due   (par_due),
        .limit_hit (limit_hit)
    );

    e1iw_pos_sel #(.POS_W(POS_W)) i_pos (
        .clk        (clk),
        .rst        (rst),
        .load_prim  ((state == ST_IDLE) && bfa_lock),
        .prim_in    (bfa_pos),
        .cap_en     (searching && par_due),
        .cand_valid (cand_valid),
        .cand_pos   (cand_pos),
        .adopt_alt  (mf_take && mf_slot && alt_valid),
        .sel_pos    (sel_pos),
        .alt_valid  (alt_valid)
    );

    e1iw_mode_fsm i_fsm (
        .clk       (clk),
        .rst       (rst),
        .lock      (bfa_lock),
        .mf_found  (mf_found),
        .limit_hit (limit_hit),
        .ext_iw    (cfg_ext_iw),
        .state     (state),
        .irq       (t400_irq),
        .no_mf     (no_mf_flag)
    );

    assign ctrl           = decode_ctrl(state, cfg_mon_en);
    assign crc_chk_en     = ctrl.crc_chk;
    assign ebit_force_low = ctrl.ebit_low;
    assign mon_en         = ctrl.mon;
    assign par_search     = (state == ST_SEARCH) && par_due;
endmodule

// File: rtl/e1iw_checker.sv
module e1iw_checker #(
    parameter int POS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_ext_iw,
    input logic             bfa_lock,
    input logic [POS_W-1:0] sel_pos,
    input logic             no_mf_flag,
    input logic             t400_irq,
    input logic             crc_chk_en,
    input logic             ebit_force_low,
    input logic             mon_en,
    input logic             par_search
);
    p_excl_modes_r4: assert property (@(posedge clk) disable iff (rst)
        !(crc_chk_en && ebit_force_low));

    p_mon_needs_crc_r6: assert property (@(posedge clk) disable iff (rst)
        mon_en |-> crc_chk_en);

    p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
        t400_irq |=> !t400_irq);

    p_irq_fallback_r7: assert property (@(posedge clk) disable iff (rst)
        t400_irq |-> (no_mf_flag && ebit_force_low && !crc_chk_en));

    p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        no_mf_flag |=> no_mf_flag);

    p_ext_no_irq_r9: assert property (@(posedge clk) disable iff (rst)
        cfg_ext_iw |=> !t400_irq);

    p_pos_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (par_search && bfa_lock) |=> (!par_search || $stable(sel_pos)));

    p_unlock_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !bfa_lock |=> (!crc_chk_en && !ebit_force_low && !par_search && !mon_en));
endmodule

bind e1_mf_interwork_ctrl e1iw_checker i_chk (.*);

// File: tb/test_e1_mf_interwork_ctrl.sv
module test_e1_mf_interwork_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_ext_iw = 1'b0;
    logic       cfg_mon_en = 1'b1;
    logic       bfa_lock = 1'b0;
    logic [7:0] bfa_pos = '0;
    logic       cand_valid = 1'b0;
    logic [7:0] cand_pos = '0;
    logic       mf_found = 1'b0;
    logic       mf_slot = 1'b0;
    logic       ms_tick = 1'b0;
    logic [7:0] sel_pos;
    logic       no_mf_flag, t400_irq, crc_chk_en, ebit_force_low, mon_en, par_search;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    e1_mf_interwork_ctrl i_e1_mf_interwork_ctrl (
        .clk(clk), .rst(rst), .cfg_ext_iw(cfg_ext_iw), .cfg_mon_en(cfg_mon_en),
        .bfa_lock(bfa_lock), .bfa_pos(bfa_pos), .cand_valid(cand_valid),
        .cand_pos(cand_pos), .mf_found(mf_found), .mf_slot(mf_slot),
        .ms_tick(ms_tick), .sel_pos(sel_pos), .no_mf_flag(no_mf_flag),
        .t400_irq(t400_irq), .crc_chk_en(crc_chk_en),
        .ebit_force_low(ebit_force_low), .mon_en(mon_en), .par_search(par_search)
    );

    typedef struct packed {
        logic       lock;
        logic [7:0] pos;
        logic       mf;
        logic       slot;
        logic       cv;
        logic [7:0] cpos;
        logic       e_crc;
        logic       e_force;
        logic       e_mon;
        logic [7:0] e_sel;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0},
        '{1'b1, 8'd5, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b1, 8'd0, 1'b1, 1'b0, 1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 8'd5},
        '{1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd5},
        '{1'b1, 8'd9, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd9},
        '{1'b1, 8'd0, 1'b0, 1'b0, 1'b1, 8'd3, 1'b0, 1'b0, 1'b0, 8'd9},
        '{1'b1, 8'd0, 1'b1, 1'b1, 1'b0, 8'd0, 1'b1, 1'b0, 1'b1, 8'd9},
        '{1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd0, 1'b0, 1'b0, 1'b0, 8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            ms_tick = 1'b1;
            @(negedge clk);
        end
        ms_tick = 1'b0;
    endtask

    task automatic pulse_mf(input logic slot);
        mf_found = 1'b1;
        mf_slot  = slot;
        step();
        mf_found = 1'b0;
        mf_slot  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bfa_lock = 1'b0;
        step();
        step();
        rst = 1'b0;
        step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 sel_pos", sel_pos, 0);
        check("R1 no_mf_flag", no_mf_flag, 0);
        check("R1 t400_irq", t400_irq, 0);
        check("R1 crc_chk_en", crc_chk_en, 0);
        check("R1 ebit_force_low", ebit_force_low, 0);
        check("R1 mon_en", mon_en, 0);
        check("R1 par_search", par_search, 0);

        // Vector walk: R2 R4 R5 R6 R10
        for (int v = 0; v < NV; v++) begin
            bfa_lock   = VECS[v].lock;
            bfa_pos    = VECS[v].pos;
            mf_found   = VECS[v].mf;
            mf_slot    = VECS[v].slot;
            cand_valid = VECS[v].cv;
            cand_pos   = VECS[v].cpos;
            step();
            check("R4 vec crc_chk_en", crc_chk_en, VECS[v].e_crc);
            check("R10 vec ebit_force_low", ebit_force_low, VECS[v].e_force);
            check("R6 vec mon_en", mon_en, VECS[v].e_mon);
            check("R2 R5 vec sel_pos", sel_pos, VECS[v].e_sel);
        end
        mf_found = 1'b0; cand_valid = 1'b0; mf_slot = 1'b0;

        // R3 parallel search and candidate adoption (R5)
        bfa_lock = 1'b1; bfa_pos = 8'd20; step();
        ticks(7);
        check("R3 par before threshold", par_search, 0);
        ticks(1);
        check("R3 par at threshold", par_search, 1);
        cand_valid = 1'b1; cand_pos = 8'd44; step(); cand_valid = 1'b0;
        check("R3 sel held during search", sel_pos, 20);
        pulse_mf(1'b1);
        check("R5 adopt candidate", sel_pos, 44);
        check("R4 crc on", crc_chk_en, 1);
        check("R6 mon with cfg", mon_en, 1);

        // R6 monitoring disabled by config
        cfg_mon_en = 1'b0;
        bfa_lock = 1'b0; step();
        check("R10 unlock crc off", crc_chk_en, 0);
        bfa_lock = 1'b1; bfa_pos = 8'd30; step();
        pulse_mf(1'b0);
        check("R6 mon off by cfg", mon_en, 0);
        check("R4 crc on slot0", crc_chk_en, 1);
        check("R5 slot0 keeps primary", sel_pos, 30);
        cfg_mon_en = 1'b1;

        // R7 timeout with a recorded candidate
        bfa_lock = 1'b0; step();
        bfa_lock = 1'b1; bfa_pos = 8'd7; step();
        ticks(8);
        cand_valid = 1'b1; cand_pos = 8'd60; step(); cand_valid = 1'b0;
        ticks(392);
        check("R7 no flag at limit", no_mf_flag, 0);
        check("R7 no irq at limit", t400_irq, 0);
        check("R7 no force at limit", ebit_force_low, 0);
        step();
        check("R7 irq pulse", t400_irq, 1);
        check("R7 flag set", no_mf_flag, 1);
        check("R7 force low", ebit_force_low, 1);
        check("R7 crc off", crc_chk_en, 0);
        check("R7 primary kept", sel_pos, 7);
        step();
        check("R7 irq one cycle", t400_irq, 0);

        // R8 ignored multiframe and sticky flag
        pulse_mf(1'b1);
        check("R8 mf ignored crc", crc_chk_en, 0);
        check("R8 mf ignored force", ebit_force_low, 1);
        check("R8 mf ignored sel", sel_pos, 7);
        bfa_lock = 1'b0; step();
        check("R10 unlock force off", ebit_force_low, 0);
        bfa_lock = 1'b1; step();
        check("R8 flag sticky", no_mf_flag, 1);

        // R9 extended interworking
        do_reset();
        check("R1 flag cleared", no_mf_flag, 0);
        cfg_ext_iw = 1'b1;
        bfa_lock = 1'b1; bfa_pos = 8'd12; step();
        ticks(450);
        step();
        check("R9 no flag", no_mf_flag, 0);
        check("R9 no irq", t400_irq, 0);
        check("R9 no force", ebit_force_low, 0);
        check("R9 still searching", par_search, 1);
        pulse_mf(1'b0);
        check("R9 late mf", crc_chk_en, 1);
        cfg_ext_iw = 1'b0;

        // R10 timer restarts on lock regain
        bfa_lock = 1'b0; step();
        check("R10 par off", par_search, 0);
        bfa_lock = 1'b1; step();
        ticks(300);
        bfa_lock = 1'b0; step();
        bfa_lock = 1'b1; step();
        ticks(300);
        step();
        check("R10 count restarted", no_mf_flag, 0);
        ticks(100);
        step();
        check("R10 limit after regain", no_mf_flag, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule